// File: doc/BRIEF.md
# Trace and Graticule Rasterizer

This block turns a stream of 8-bit waveform samples into bytes for a 320 by 240 monochrome frame buffer. The buffer is stored column by column. Each column holds 30 bytes, and each byte covers 8 vertically stacked pixels, with bit 0 as the topmost pixel. Each accepted sample fills one screen column. The block then writes that column's 24 trace bytes (byte rows 1 to 24, pixel rows 8 to 199) on 24 consecutive cycles. Byte row 0 and byte rows 25 to 29 belong to the text bars and are never touched.

The trace window is 192 pixels tall: 8 divisions of 24 pixels. Samples map one code per pixel around mid-scale. Codes too small or too large to land in the window are clipped. A dotted graticule and two horizontal cursor lines come from the same column and row counters that place the trace. They are ORed with the trace pixel before each byte is written. The cursor rows are read from the cursor inputs when a sample is accepted, so each column is drawn with one consistent set of values.

Top module: `rast_trace_raster`

## Requirements
- R1: After reset, `fb_we` is low, `sample_ready` is high, and the first column drawn is column 0.
- R2: A sample is accepted on a clock edge where `sample_valid` and `sample_ready` are both high. On the next cycle `sample_ready` is low and `fb_we` is still low. Starting two edges after acceptance, `fb_we` is high for exactly 24 consecutive cycles, then `sample_ready` returns high.
- R3: The 24 writes of a column go to byte rows 1, 2, ..., 24 in that order, at address column*30 + byte_row. The column advances by one after each sample and wraps from 319 to 0.
- R4: In byte row b, bit k (bit 0 topmost) is trace-window row y = 8*(b-1)+k. A sample s with 32 <= s <= 223 lights row y = 223 - s, so larger codes appear higher.
- R5: A sample below 32 or above 223 lights no trace pixel in its column.
- R6: The graticule lights row y when (column mod 32 = 0 and y mod 4 = 0) or (y mod 24 = 0 and column mod 4 = 0).
- R7: Cursor inputs A and B each light row y equal to their value in every column. A value of 192 or more lights nothing.
- R8: Changes on `sample`, `cursor_a`, `cursor_b` and `sample_valid` while a column is being drawn have no effect on that column.
- R9: Each written bit is the OR of its trace, graticule and cursor contributions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Sample offered |
| sample | input | 8 | Sample code |
| cursor_a | input | 8 | Cursor A row in the trace window |
| cursor_b | input | 8 | Cursor B row in the trace window |
| sample_ready | output | 1 | Block idle and able to take a sample |
| fb_we | output | 1 | Frame-buffer byte write strobe |
| fb_addr | output | 14 | Byte address, column*30 + byte row |
| fb_data | output | 8 | Eight vertical pixels, bit 0 topmost |

## Verification
The assertions check on every cycle the handshake and write timing. After an acceptance, `sample_ready` drops and a write follows two edges later. A column never ends early, each write lands in byte rows 1 to 24, consecutive writes step the address by one, and the column counter stays in range. The pixel contents cannot be seen by a per-cycle property: the trace mapping, clipping, graticule dots, cursor rows and their OR combination. The bench shows them by sweeping every sample code and cursor values on both sides of 192 across all 320 columns through a column wrap, scrambling the inputs during each column and comparing every byte with an arithmetic model.

// File: rtl/rast_pkg.sv
package rast_pkg;
    localparam int RAST_COLS        = 320;
    localparam int RAST_ROWS        = 240;
    localparam int RAST_TOP_BYTES   = 1;
    localparam int RAST_TRACE_BYTES = 24;
    localparam int RAST_DIV_ROWS    = 24;
    localparam int RAST_DIV_COLS    = 32;
    localparam int RAST_DOT_PITCH   = 4;
    localparam int RAST_SAMPLE_W    = 8;
    localparam int RAST_PIX_PER_BYTE = 8;
endpackage

// File: rtl/rast_column_seq.sv
module rast_column_seq #(
    parameter int COLS        = rast_pkg::RAST_COLS,
    parameter int FIRST_BROW  = rast_pkg::RAST_TOP_BYTES,
    parameter int TRACE_BYTES = rast_pkg::RAST_TRACE_BYTES,
    parameter int SAMPLE_W    = rast_pkg::RAST_SAMPLE_W,
    localparam int COL_W      = $clog2(COLS),
    localparam int BROW_W     = $clog2(FIRST_BROW + TRACE_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] cursor_a,
    input  logic [SAMPLE_W-1:0] cursor_b,
    output logic                busy,
    output logic [COL_W-1:0]    col,
    output logic [BROW_W-1:0]   brow,
    output logic [SAMPLE_W-1:0] samp_held,
    output logic [SAMPLE_W-1:0] cur_a_held,
    output logic [SAMPLE_W-1:0] cur_b_held
);
    localparam int LAST_BROW = FIRST_BROW + TRACE_BYTES - 1;

    typedef struct packed {
        logic                busy;
        logic [COL_W-1:0]    col;
        logic [BROW_W-1:0]   brow;
        logic [SAMPLE_W-1:0] samp;
        logic [SAMPLE_W-1:0] cur_a;
        logic [SAMPLE_W-1:0] cur_b;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d    = s_q;
        accept = !s_q.busy && sample_valid;
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.brow  = BROW_W'(FIRST_BROW);
            s_d.samp  = sample;
            s_d.cur_a = cursor_a;
            s_d.cur_b = cursor_b;
        end else if (s_q.busy) begin
            if (s_q.brow == BROW_W'(LAST_BROW)) begin
                s_d.busy = 1'b0;
                s_d.col  = (s_q.col == COL_W'(COLS - 1)) ? '0 : s_q.col + 1'b1;
            end else begin
                s_d.brow = s_q.brow + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.brow <= BROW_W'(FIRST_BROW);
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = s_q.busy;
    assign col        = s_q.col;
    assign brow       = s_q.brow;
    assign samp_held  = s_q.samp;
    assign cur_a_held = s_q.cur_a;
    assign cur_b_held = s_q.cur_b;

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(s_q.col) < 32'(COLS)); // R3
    AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.brow != BROW_W'(LAST_BROW)) |=> s_q.busy); // R2
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> $stable(s_q.samp)); // R8
endmodule

// File: rtl/rast_byte_gen.sv
module rast_byte_gen #(
    parameter int COL_W       = 9,
    parameter int BROW_W      = 5,
    parameter int SAMPLE_W    = rast_pkg::RAST_SAMPLE_W,
    parameter int FIRST_BROW  = rast_pkg::RAST_TOP_BYTES,
    parameter int TRACE_BYTES = rast_pkg::RAST_TRACE_BYTES,
    parameter int DIV_ROWS    = rast_pkg::RAST_DIV_ROWS,
    parameter int DIV_COLS    = rast_pkg::RAST_DIV_COLS,
    parameter int DOT_PITCH   = rast_pkg::RAST_DOT_PITCH,
    localparam int PIX        = rast_pkg::RAST_PIX_PER_BYTE
) (
    input  logic [COL_W-1:0]    col,
    input  logic [BROW_W-1:0]   brow,
    input  logic [SAMPLE_W-1:0] samp,
    input  logic [SAMPLE_W-1:0] cur_a,
    input  logic [SAMPLE_W-1:0] cur_b,
    output logic [PIX-1:0]      pix_byte
);
    localparam int TRACE_PIX = TRACE_BYTES * PIX;
    localparam logic [31:0] CLIP_LO = 32'(((1 << SAMPLE_W) - TRACE_PIX) / 2);
    localparam logic [31:0] CLIP_HI = CLIP_LO + 32'(TRACE_PIX) - 32'd1;
    localparam logic [31:0] DR = 32'(DIV_ROWS);
    localparam logic [31:0] DC = 32'(DIV_COLS);
    localparam logic [31:0] DP = 32'(DOT_PITCH);

    logic [31:0] col32, samp32, row_base;
    logic        samp_in_win, col_on_div, col_on_dot;

    assign col32       = 32'(col);
    assign samp32      = 32'(samp);
    assign row_base    = (32'(brow) - 32'(FIRST_BROW)) * 32'(PIX);
    assign samp_in_win = (samp32 >= CLIP_LO) && (samp32 <= CLIP_HI);
    assign col_on_div  = (col32 % DC) == 32'd0;
    assign col_on_dot  = (col32 % DP) == 32'd0;

    for (genvar k = 0; k < PIX; k++) begin : g_pix
        logic [31:0] ty;
        logic        hit_trace, hit_grat, hit_cur;
        assign ty        = row_base + 32'(k);
        assign hit_trace = samp_in_win && (ty == CLIP_HI - samp32);
        assign hit_grat  = (col_on_div && (ty % DP) == 32'd0)
                        || (col_on_dot && (ty % DR) == 32'd0);
        assign hit_cur   = (ty == 32'(cur_a)) || (ty == 32'(cur_b));
        assign pix_byte[k] = hit_trace | hit_grat | hit_cur;
    end
endmodule

// File: rtl/rast_trace_raster.sv
module rast_trace_raster #(
    parameter int COLS        = rast_pkg::RAST_COLS,
    parameter int ROWS        = rast_pkg::RAST_ROWS,
    parameter int TOP_BYTES   = rast_pkg::RAST_TOP_BYTES,
    parameter int TRACE_BYTES = rast_pkg::RAST_TRACE_BYTES,
    parameter int DIV_ROWS    = rast_pkg::RAST_DIV_ROWS,
    parameter int DIV_COLS    = rast_pkg::RAST_DIV_COLS,
    parameter int DOT_PITCH   = rast_pkg::RAST_DOT_PITCH,
    parameter int SAMPLE_W    = rast_pkg::RAST_SAMPLE_W,
    localparam int PIX        = rast_pkg::RAST_PIX_PER_BYTE,
    localparam int BYTES_PER_COL = ROWS / PIX,
    localparam int ADDR_W     = $clog2(COLS * BYTES_PER_COL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] cursor_a,
    input  logic [SAMPLE_W-1:0] cursor_b,
    output logic                sample_ready,
    output logic                fb_we,
    output logic [ADDR_W-1:0]   fb_addr,
    output logic [PIX-1:0]      fb_data
);
    localparam int COL_W  = $clog2(COLS);
    localparam int BROW_W = $clog2(TOP_BYTES + TRACE_BYTES);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [PIX-1:0]    data;
    } out_t;

    logic                busy;
    logic [COL_W-1:0]    col;
    logic [BROW_W-1:0]   brow;
    logic [SAMPLE_W-1:0] samp_h, cur_a_h, cur_b_h;
    logic [PIX-1:0]      pix_byte;
    out_t                o_d, o_q;

    rast_column_seq #(
        .COLS(COLS), .FIRST_BROW(TOP_BYTES), .TRACE_BYTES(TRACE_BYTES),
        .SAMPLE_W(SAMPLE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample(sample), .cursor_a(cursor_a), .cursor_b(cursor_b),
        .busy(busy), .col(col), .brow(brow), .samp_held(samp_h),
        .cur_a_held(cur_a_h), .cur_b_held(cur_b_h)
    );

    rast_byte_gen #(
        .COL_W(COL_W), .BROW_W(BROW_W), .SAMPLE_W(SAMPLE_W),
        .FIRST_BROW(TOP_BYTES), .TRACE_BYTES(TRACE_BYTES),
        .DIV_ROWS(DIV_ROWS), .DIV_COLS(DIV_COLS), .DOT_PITCH(DOT_PITCH)
    ) u_byte (
        .col(col), .brow(brow), .samp(samp_h), .cur_a(cur_a_h),
        .cur_b(cur_b_h), .pix_byte(pix_byte)
    );

    always_comb begin
        o_d      = o_q;
        o_d.we   = busy;
        o_d.addr = ADDR_W'(32'(col) * 32'(BYTES_PER_COL) + 32'(brow));
        o_d.data = busy ? pix_byte : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign sample_ready = !busy;
    assign fb_we        = o_q.we;
    assign fb_addr      = o_q.addr;
    assign fb_data      = o_q.data;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample_ready) |=> !sample_ready); // R2
    AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample_ready) |-> ##2 fb_we); // R2
    AST_ROW_IN_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ((32'(fb_addr) % 32'(BYTES_PER_COL)) >= 32'(TOP_BYTES)
               && (32'(fb_addr) % 32'(BYTES_PER_COL)) < 32'(TOP_BYTES + TRACE_BYTES))); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |-> fb_addr == $past(fb_addr) + 1'b1); // R3
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ready |=> !fb_we); // R2
endmodule

// File: tb/rast_trace_raster_bench.sv
module rast_trace_raster_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [7:0]  sample = '0, cursor_a = '0, cursor_b = '0;
    logic        sample_ready, fb_we;
    logic [13:0] fb_addr;
    logic [7:0]  fb_data;

    int checks = 0, failures = 0;
    int m_s = 0, m_ca = 0, m_cb = 0;
    int exp_col = 0, exp_brow = 1, wr_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rast_trace_raster u_rast_trace_raster (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
        .cursor_a(cursor_a), .cursor_b(cursor_b), .sample_ready(sample_ready),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data)
    );

    function automatic int model_byte(int c, int b, int s, int ca, int cb);
        int r = 0;
        for (int k = 0; k < 8; k++) begin
            int y = 8 * (b - 1) + k;
            bit tr = (s >= 32) && (s <= 223) && (y == 223 - s);    // R4 R5
            bit gr = ((c % 32 == 0) && (y % 4 == 0))
                  || ((y % 24 == 0) && (c % 4 == 0));               // R6
            bit cu = (y == ca) || (y == cb);                        // R7
            if (tr || gr || cu) r |= (1 << k);                      // R9
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, int got, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // write monitor, sampled 1 ns after the active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && fb_we) begin
                chk(32'(fb_addr) == exp_col * 30 + exp_brow, "R1 R3 address",
                    int'(fb_addr), exp_col * 30 + exp_brow);
                chk(int'(fb_data) == model_byte(exp_col, exp_brow, m_s, m_ca, m_cb),
                    "R4 R5 R6 R7 R8 R9 data", int'(fb_data),
                    model_byte(exp_col, exp_brow, m_s, m_ca, m_cb));
                wr_cnt++;
                exp_brow++;
                if (exp_brow > 24) begin
                    exp_brow = 1;
                    exp_col  = (exp_col + 1) % 320;
                end
            end
        end
    end

    task automatic feed(int s, int ca, int cb);
        sample_valid = 1'b1;
        sample   = 8'(s);
        cursor_a = 8'(ca);
        cursor_b = 8'(cb);
        while (!sample_ready) @(negedge clk);
        m_s = s; m_ca = ca; m_cb = cb;
        wr_cnt = 0;
        @(negedge clk);
        chk(!sample_ready, "R2 ready low after accept", int'(sample_ready), 0);
        chk(!fb_we, "R2 no write one cycle after accept", int'(fb_we), 0);
        sample   = ~8'(s);          // R8 scramble while busy
        cursor_a = 8'(ca + 7);
        cursor_b = 8'(cb) ^ 8'h55;
        @(negedge clk);
        chk(fb_we, "R2 write two edges after accept", int'(fb_we), 1);
        sample = 8'(s + 1);
        while (!sample_ready) @(negedge clk);
        chk(wr_cnt == 24, "R2 writes per column", wr_cnt, 24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!fb_we, "R1 no write in reset", int'(fb_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fb_we, "R1 no write after reset", int'(fb_we), 0);
        chk(sample_ready, "R1 ready after reset", int'(sample_ready), 1);
        // frame 1: every sample code, cursor A sweeping past 192
        for (int c = 0; c < 320; c++) feed(c % 256, c % 200, 191);
        // frame 2: scattered codes, column wrap, cursor B near and past the top
        for (int c = 0; c < 330; c++) feed((c * 37 + 5) % 256, 0, 255 - (c % 70));
        sample_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!fb_we, "R2 idle without samples", int'(fb_we), 0);
        chk(exp_col == 10, "R3 column after wrap", exp_col, 10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired R2 got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule